// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block forms the byte that a flash-style memory returns on its data bus when the host reads it while a program or erase runs inside the memory. A separate controller supplies the operation kind, the phase it is in (accept window, running, finished, failed, suspended), bit 7 of the byte being programmed, and a flag telling whether the address being read lies inside a sector chosen for erasure. From these the block forms the polling bit, the two toggle bits, the time-limit bit and the window bit. When no status is due, it passes the array data through unchanged.

The toggle bits are held in flip-flops that advance once per completed host read, not per clock. A host that reads twice in a row therefore sees them differ while the operation is busy. A failure is latched, so the time-limit bit stays set until a reset command arrives, even if the phase inputs move on.

Top module: `emb_status_gen`

## Requirements
- R1: After reset both toggle flip-flops are 0, so the first status read during a program shows bit 6 = 0, and with the phase idle the bus equals the array data.
- R2: In the idle phase (0) and the finished phase (3), with no failure latched, the bus carries the array data unchanged.
- R3: A program (op = 0) in the running phase (2) or window phase (1) shows bit 7 = inverse of the programmed bit 7 and bit 5 = 0. Bit 6 inverts on every completed read.
- R4: The toggle bits change only on a completed read (rd_done high for one cycle). With no read they hold for any number of clocks.
- R5: An erase (op = 1) in the running phase shows bit 7 = 0, bit 5 = 0 and bit 3 = 1. A read in an erasing sector inverts both bit 6 and bit 2.
- R6: An erase in the accept-window phase (1) shows bit 3 = 0, and bits 6 and 2 toggle as in R5.
- R7: The failed phase (4) latches a failure. While it is latched: bit 5 = 1, bit 7 keeps its in-progress value, bit 6 keeps toggling, and for an erase bit 3 = 1. This holds whatever the phase input does later, until reset_cmd is high at a clock edge.
- R8: In the suspended phase (5), an erase read inside a suspended sector shows bit 7 = 1, bit 5 = 0 and bit 3 = 0. Bit 6 holds across reads and bit 2 inverts on each read.
- R9: In the suspended phase, a read outside the suspended sectors returns the array data unchanged.
- R10: Bit 2 advances only for erase reads inside an erasing or suspended sector. An erase read elsewhere while busy inverts bit 6 but leaves bit 2 unchanged.
- R11: In every status byte, bits 4, 1 and 0 and every bit above 7 are 0. For a program, bits 3 and 2 are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 1 | Operation kind: 0 program, 1 erase |
| phase | input | 3 | 0 idle, 1 accept window, 2 running, 3 finished, 4 failed, 5 suspended |
| in_sector | input | 1 | Read address lies in a sector being erased or suspended |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| rd_done | input | 1 | One-cycle pulse marking a completed host read |
| reset_cmd | input | 1 | Reset command; clears a latched failure |
| array_data | input | DW | Data read from the array |
| bus_data | output | DW | Byte presented to the host |

## Verification
The hardest case to reach from the ports is a failure that persists after the phase input has left the failed phase. The bench holds the failed phase for one clock, moves the phase to idle, and checks that the time-limit bit, the polling bit and the window bit still read as failed. Only after a reset_cmd pulse must the array data reappear. Suspend-versus-running toggle behaviour is reached by issuing read pulses in each phase and comparing bits 6 and 2 before and after each pulse.

// File: rtl/emb_status_pkg.sv
package emb_status_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WINDOW = 3'd1,
        PH_BUSY   = 3'd2,
        PH_DONE   = 3'd3,
        PH_FAIL   = 3'd4,
        PH_SUSP   = 3'd5
    } phase_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_LIM  = 5;
    localparam int BIT_WIN  = 3;
    localparam int BIT_ALT  = 2;
    localparam int NUM_TOG  = 2;
    localparam int IDX_MAIN = 0;
    localparam int IDX_ALT  = 1;

    // phases in which the operation is still working
    function automatic logic is_running(phase_e ph);
        return (ph == PH_WINDOW) || (ph == PH_BUSY) || (ph == PH_FAIL);
    endfunction

    // whether a read returns status instead of array data
    function automatic logic shows_status(op_e o, phase_e ph, logic in_sec);
        return is_running(ph) || ((ph == PH_SUSP) && (o == OP_ERASE) && in_sec);
    endfunction

    // whether the alternate toggle (bit 2) may advance on this read
    function automatic logic alt_moves(op_e o, phase_e ph, logic in_sec);
        return (o == OP_ERASE) && in_sec && (is_running(ph) || (ph == PH_SUSP));
    endfunction

endpackage

// File: rtl/emb_toggle_bank.sv
module emb_toggle_bank #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] adv,
    output logic [NUM-1:0] q
);
    for (genvar i = 0; i < NUM; i++) begin : g_tog
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (adv[i])
                bit_q <= ~bit_q;
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/emb_status_compose.sv
module emb_status_compose
    import emb_status_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e                  op,
    input  phase_e               eff_phase,
    input  logic                 in_sector,
    input  logic                 prog_d7,
    input  logic [NUM_TOG-1:0]   tog,
    input  logic [DW-1:0]        array_data,
    output logic [DW-1:0]        bus_data
);
    logic [DW-1:0] stat;

    always_comb begin
        stat = '0;
        if (op == OP_PROG) begin
            stat[BIT_POLL] = ~prog_d7;
            stat[BIT_TOG]  = tog[IDX_MAIN];
            stat[BIT_LIM]  = (eff_phase == PH_FAIL);
        end else begin
            stat[BIT_POLL] = (eff_phase == PH_SUSP);
            stat[BIT_TOG]  = tog[IDX_MAIN];
            stat[BIT_LIM]  = (eff_phase == PH_FAIL);
            stat[BIT_WIN]  = (eff_phase == PH_BUSY) || (eff_phase == PH_FAIL);
            stat[BIT_ALT]  = tog[IDX_ALT];
        end
        bus_data = shows_status(op, eff_phase, in_sector) ? stat : array_data;
    end
endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
    import emb_status_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op,
    input  logic [2:0]    phase,
    input  logic          in_sector,
    input  logic          prog_d7,
    input  logic          rd_done,
    input  logic          reset_cmd,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] bus_data
);
    op_e                op_t;
    phase_e             ph_in;
    phase_e             eff;
    logic               fail_q;
    logic [NUM_TOG-1:0] adv;
    logic [NUM_TOG-1:0] tog;

    assign op_t  = op_e'(op);
    assign ph_in = phase_e'(phase);
    assign eff   = fail_q ? PH_FAIL : ph_in;

    // failure latch: set by the failed phase, cleared only by a reset command
    always_ff @(posedge clk) begin
        if (rst || reset_cmd)
            fail_q <= 1'b0;
        else if (ph_in == PH_FAIL)
            fail_q <= 1'b1;
    end

    always_comb begin
        adv           = '0;
        adv[IDX_MAIN] = rd_done && is_running(eff);
        adv[IDX_ALT]  = rd_done && alt_moves(op_t, eff, in_sector);
    end

    emb_toggle_bank #(.NUM(NUM_TOG)) u_tog (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .q   (tog)
    );

    emb_status_compose #(.DW(DW)) u_comp (
        .op         (op_t),
        .eff_phase  (eff),
        .in_sector  (in_sector),
        .prog_d7    (prog_d7),
        .tog        (tog),
        .array_data (array_data),
        .bus_data   (bus_data)
    );
endmodule

// File: rtl/emb_status_chk.sv
module emb_status_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          op,
    input logic [2:0]    phase,
    input logic          in_sector,
    input logic          prog_d7,
    input logic          rd_done,
    input logic          reset_cmd,
    input logic [DW-1:0] array_data,
    input logic [DW-1:0] bus_data,
    input logic          fail_held
);
    logic steady;
    assign steady = !rd_done && !reset_cmd && (phase != 3'd4);

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!fail_held && (phase == 3'd0 || phase == 3'd3)) |-> (bus_data == array_data)) else $error("idle pass"); // R2

    AST_PROG_COMPL: assert property (@(posedge clk) disable iff (rst)
        (!fail_held && op == 1'b0 && phase == 3'd2) |-> (bus_data[7] == !prog_d7 && !bus_data[5])) else $error("prog poll"); // R3

    AST_Q6_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !reset_cmd && !fail_held && op == 1'b0 && phase == 3'd2)
        |=> ((op == 1'b0 && phase == 3'd2) -> (bus_data[6] != $past(bus_data[6])))) else $error("q6 advance"); // R3

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        steady |=> (($stable(op) && $stable(phase) && $stable(in_sector) && $stable(prog_d7)
                     && $stable(array_data)) -> $stable(bus_data))) else $error("hold"); // R4

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && !reset_cmd) |=> bus_data[5]) else $error("fail sticky"); // R7

    AST_SUSP_Q6_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !reset_cmd && !fail_held && op == 1'b1 && phase == 3'd5 && in_sector)
        |=> ((op == 1'b1 && phase == 3'd5 && in_sector) -> $stable(bus_data[6]))) else $error("susp q6"); // R8
endmodule

bind emb_status_gen emb_status_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .phase      (phase),
    .in_sector  (in_sector),
    .prog_d7    (prog_d7),
    .rd_done    (rd_done),
    .reset_cmd  (reset_cmd),
    .array_data (array_data),
    .bus_data   (bus_data),
    .fail_held  (fail_q)
);

// File: tb/emb_status_gen_tb.sv
module emb_status_gen_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       op;
    logic [2:0] phase;
    logic       in_sector;
    logic       prog_d7;
    logic       rd_done;
    logic       reset_cmd;
    logic [7:0] array_data;
    logic [7:0] bus_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    emb_status_gen #(.DW(8)) u_dut (
        .clk(clk), .rst(rst), .op(op), .phase(phase), .in_sector(in_sector),
        .prog_d7(prog_d7), .rd_done(rd_done), .reset_cmd(reset_cmd),
        .array_data(array_data), .bus_data(bus_data)
    );

    // op, phase, in_sector, d7, array, expected, mask
    localparam int NV = 9;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 3'd0, 1'b0, 1'b0, 8'hA5, 8'hA5, 8'hFF},   // R2 idle
        {1'b0, 3'd3, 1'b0, 1'b0, 8'h3C, 8'h3C, 8'hFF},   // R2 done
        {1'b0, 3'd2, 1'b0, 1'b1, 8'h5A, 8'h00, 8'hBF},   // R3 R11
        {1'b0, 3'd2, 1'b0, 1'b0, 8'h5A, 8'h80, 8'hBF},   // R3
        {1'b1, 3'd2, 1'b1, 1'b0, 8'hC3, 8'h08, 8'hBB},   // R5
        {1'b1, 3'd1, 1'b1, 1'b0, 8'hC3, 8'h00, 8'hBB},   // R6
        {1'b1, 3'd5, 1'b1, 1'b0, 8'hC3, 8'h80, 8'hBB},   // R8
        {1'b1, 3'd5, 1'b0, 1'b0, 8'h77, 8'h77, 8'hFF},   // R9
        {1'b1, 3'd2, 1'b0, 1'b0, 8'h11, 8'h08, 8'hBB}    // R5 R10
    };
    localparam string TAG [NV] = '{"R2", "R2", "R3", "R3", "R5", "R6", "R8", "R9", "R10"};

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
        n_chk++;
        if ((act & mask) !== (exp & mask)) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h mask=%02h", tag, act, exp, mask);
        end
    endtask

    task automatic set_in(logic o, logic [2:0] p, logic s, logic d, logic [7:0] a);
        @(negedge clk);
        op = o; phase = p; in_sector = s; prog_d7 = d; array_data = a;
        #1;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        #1;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] a;
        logic [7:0] b;
        rst = 1'b1; op = 1'b0; phase = 3'd0; in_sector = 1'b0; prog_d7 = 1'b0;
        rd_done = 1'b0; reset_cmd = 1'b0; array_data = 8'h96;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", bus_data, 8'h96, 8'hFF);                 // R1 idle after reset
        set_in(1'b0, 3'd2, 1'b0, 1'b0, 8'h00);
        chk("R1", bus_data, 8'h80, 8'hFF);                 // R1 toggle cleared

        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i][29], VEC[i][28:26], VEC[i][25], VEC[i][24], VEC[i][23:16]);
            chk(TAG[i], bus_data, VEC[i][15:8], VEC[i][7:0]);
        end

        // R3: bit 6 alternates on each read during program
        set_in(1'b0, 3'd2, 1'b0, 1'b1, 8'hFF);
        a = bus_data;
        do_read();
        chk("R3", bus_data, {a[7], ~a[6], a[5:0]}, 8'hFF);
        do_read();
        chk("R3", bus_data, a, 8'hFF);

        // R4: no read, no change
        a = bus_data;
        repeat (6) @(negedge clk);
        #1;
        chk("R4", bus_data, a, 8'hFF);

        // R5: erase running, in sector: bits 6 and 2 both flip
        set_in(1'b1, 3'd2, 1'b1, 1'b0, 8'hFF);
        a = bus_data;
        do_read();
        chk("R5", bus_data, a ^ 8'h44, 8'hFF);

        // R6: window: bit 3 low, toggles flip
        set_in(1'b1, 3'd1, 1'b1, 1'b0, 8'hFF);
        a = bus_data;
        chk("R6", a, 8'h00, 8'h08);
        do_read();
        chk("R6", bus_data, a ^ 8'h44, 8'hFF);

        // R10: erase read outside sector: bit 6 flips, bit 2 holds
        set_in(1'b1, 3'd2, 1'b0, 1'b0, 8'hFF);
        a = bus_data;
        do_read();
        chk("R10", bus_data, a ^ 8'h40, 8'hFF);
        // R11: program status keeps bits 3 and 2 low
        set_in(1'b0, 3'd2, 1'b0, 1'b0, 8'hFF);
        chk("R11", bus_data, 8'h80, 8'hBF);

        // R8: suspended, in sector: bit 6 holds, bit 2 flips
        set_in(1'b1, 3'd5, 1'b1, 1'b0, 8'hFF);
        a = bus_data;
        do_read();
        chk("R8", bus_data, a ^ 8'h04, 8'hFF);

        // R7: failure stays latched after phase leaves failed
        set_in(1'b1, 3'd4, 1'b1, 1'b0, 8'hFF);
        @(negedge clk);
        phase = 3'd0;
        #1;
        a = bus_data;
        chk("R7", a, 8'h28, 8'hBB);
        do_read();
        b = bus_data;
        chk("R7", b, a ^ 8'h44, 8'hFF);
        @(negedge clk);
        reset_cmd = 1'b1;
        @(negedge clk);
        reset_cmd = 1'b0;
        #1;
        chk("R7", bus_data, 8'hFF, 8'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule